// File: doc/BRIEF.md
# Pipelined Core Debug Halt Controller

This block decides when a simple pipelined processor core stops normal execution and enters debug state. Each instruction that reaches the execute stage carries an address and a breakpoint tag. The data memory stage raises a one-cycle pulse when an access matches a watchpoint. An external halt request can also stop the core. The controller tells the pipeline which execute-stage instruction to cancel. It raises a halted flag and an interrupt mask. It also keeps the program counter at which execution should continue, and a code that names what caused the halt.

Breakpoints stop the core precisely: the tagged instruction is cancelled in execute and becomes the resume point. Watchpoints stop it imprecisely. The instruction that follows the matching access always finishes. That may take several cycles while the core reports itself busy. The next instruction to reach execute is then cancelled, and the captured value is that instruction's address plus five instruction widths. If the finishing instruction redirected the flow, that address comes from the new flow. Debug state holds until a one-cycle resume pulse. A breakpoint that is still set fires again when the instruction comes back through execute.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: Debug state starts only when an instruction marked with a breakpoint is valid in execute. In that cycle `ex_squash` is high. From the next edge onward `dbg_active` is 1, `cause` is 01 and `cap_pc` holds that instruction's address. A breakpoint flag that arrives with `ex_valid` low has no effect.
- R2: After a resume, an instruction that comes back to execute with its breakpoint still set makes the controller enter debug state again, with cause 01.
- R3: `irq_mask` is 1 from the edge that enters debug state until the edge that follows the resume pulse, and on that edge it returns to 0.
- R4: The instruction that is in execute in the cycle of the watchpoint pulse is never cancelled. If it completes in that same cycle (`ex_done` high, `ex_busy` low), the next valid instruction, one cycle later, is cancelled and debug state begins on the following edge.
- R5: While the follow-on instruction has `ex_busy` high or `ex_done` low, no instruction is cancelled. The instruction cancelled is the first valid one after the follow-on completes. Cycles in which `ex_valid` is low are skipped.
- R6: On a watchpoint halt, `cause` is 10 and `cap_pc` equals the address of the cancelled instruction plus 5 × 4 bytes = 20. This holds even when that address was reached through a branch taken by the follow-on instruction.
- R7: If a breakpoint is valid in execute while a watchpoint is pending, the breakpoint halt wins: `cause` is 01, `cap_pc` is the breakpoint address and `wp_seen` is 1. On all other halts `wp_seen` is 0.
- R8: An external request `ext_req` with no watchpoint pending cancels the valid instruction in execute and halts with cause 11 and `cap_pc` equal to that instruction's address.
- R9: `dbg_active` stays 1 until a resume pulse. Breakpoints, watchpoint pulses and external requests that arrive in debug state do not cancel anything and do not change `cause` or `cap_pc`. A resume pulse outside debug state has no effect.
- R10: Outside debug state `cause` reads 00, and the resume edge clears it to 00.
- R11: During and right after reset, `dbg_active`, `irq_mask`, `ex_squash`, `wp_seen` and `cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | An instruction occupies execute |
| ex_bkpt | input | 1 | Breakpoint tag of the execute instruction |
| ex_pc | input | PC_W | Address of the execute instruction |
| ex_done | input | 1 | The execute instruction completes this cycle |
| ex_busy | input | 1 | The execute instruction needs more cycles |
| mem_wp | input | 1 | Watchpoint match pulse from the memory stage |
| ext_req | input | 1 | External halt request |
| resume | input | 1 | One-cycle pulse that leaves debug state |
| dbg_active | output | 1 | Core is in debug state |
| ex_squash | output | 1 | Cancel the execute instruction (no state update) |
| irq_mask | output | 1 | Internal interrupt mask |
| cause | output | 2 | Halt cause: 00 none, 01 breakpoint, 10 watchpoint, 11 external |
| wp_seen | output | 1 | A watchpoint was pending when a breakpoint halt won |
| cap_pc | output | PC_W | Program counter captured at entry |

## Verification
The bound checker tests these rules on every cycle:
- a breakpoint in execute leads to debug state with cause 01 on the next edge;
- entry happens only through a cancelled instruction;
- the halted flag, cause and captured value stay unchanged until resume;
- the interrupt mask tracks entry and exit;
- the cause reads 00 outside debug state.

Only the bench's scenarios can show the watchpoint timing. They cover the one-cycle skip past a single-cycle follow-on, the wait while the core is busy, the skipping of empty execute slots, and the capture of a branch target plus the 20-byte offset. The same holds for the breakpoint-over-watchpoint priority, for re-entry after resume, and for external requests.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_BKPT  = 2'b01,
      CAUSE_WATCH = 2'b10,
      CAUSE_EXT   = 2'b11
   } cause_e;

   typedef enum logic [1:0] {
      WP_IDLE  = 2'b00,
      WP_WAIT  = 2'b01,
      WP_ARMED = 2'b10
   } wp_state_e;

   typedef struct packed {
      logic   hit;
      cause_e cause;
      logic   wp_also;
   } entry_t;
endpackage

// File: rtl/dbg_wp_tracker.sv
module dbg_wp_tracker
   import dbg_entry_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dbg_active,
   input  logic entry,
   input  logic mem_wp,
   input  logic follow_done,
   output logic armed,
   output logic pending,
   output logic idle
);
   wp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (dbg_active || entry) begin
         state_d = WP_IDLE;
      end else begin
         unique case (state_q)
            WP_IDLE:  if (mem_wp) state_d = follow_done ? WP_ARMED : WP_WAIT;
            WP_WAIT:  if (follow_done) state_d = WP_ARMED;
            WP_ARMED: state_d = WP_ARMED;
            default:  state_d = WP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WP_IDLE;
      else        state_q <= state_d;
   end

   assign armed   = (state_q == WP_ARMED);
   assign idle    = (state_q == WP_IDLE);
   assign pending = !idle || mem_wp;
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
   import dbg_entry_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned WP_SKEW    = 5,
   parameter bit          EXT_EN     = 1'b1
) (
   input  logic            dbg_active,
   input  logic            ex_valid,
   input  logic            ex_bkpt,
   input  logic [PC_W-1:0] ex_pc,
   input  logic            armed,
   input  logic            wp_pending,
   input  logic            wp_idle,
   input  logic            mem_wp,
   input  logic            ext_req,
   output entry_t          ent,
   output logic [PC_W-1:0] entry_pc
);
   localparam logic [PC_W-1:0] SKEW_BYTES = PC_W'(WP_SKEW * INSN_BYTES);

   logic run_slot, bkpt_hit, wp_hit, ext_hit;

   assign run_slot = !dbg_active && ex_valid;
   assign bkpt_hit = run_slot && ex_bkpt;
   assign wp_hit   = run_slot && armed;

   generate
      if (EXT_EN) begin : g_ext
         assign ext_hit = run_slot && ext_req && wp_idle && !mem_wp;
      end else begin : g_no_ext
         assign ext_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ent      = '{hit: 1'b0, cause: CAUSE_NONE, wp_also: 1'b0};
      entry_pc = ex_pc;
      if (bkpt_hit) begin
         ent = '{hit: 1'b1, cause: CAUSE_BKPT, wp_also: wp_pending};
      end else if (wp_hit) begin
         ent      = '{hit: 1'b1, cause: CAUSE_WATCH, wp_also: 1'b0};
         entry_pc = ex_pc + SKEW_BYTES;
      end else if (ext_hit) begin
         ent = '{hit: 1'b1, cause: CAUSE_EXT, wp_also: 1'b0};
      end
   end
endmodule

// File: rtl/dbg_state_reg.sv
module dbg_state_reg
   import dbg_entry_pkg::*;
#(
   parameter int unsigned PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  entry_t          ent,
   input  logic [PC_W-1:0] entry_pc,
   input  logic            resume,
   output logic            dbg_active,
   output logic            irq_mask,
   output cause_e          cause,
   output logic            wp_seen,
   output logic [PC_W-1:0] cap_pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_active <= 1'b0;
         irq_mask   <= 1'b0;
         cause      <= CAUSE_NONE;
         wp_seen    <= 1'b0;
         cap_pc     <= '0;
      end else if (dbg_active) begin
         if (resume) begin
            dbg_active <= 1'b0;
            irq_mask   <= 1'b0;
            cause      <= CAUSE_NONE;
            wp_seen    <= 1'b0;
         end
      end else if (ent.hit) begin
         dbg_active <= 1'b1;
         irq_mask   <= 1'b1;
         cause      <= ent.cause;
         wp_seen    <= ent.wp_also;
         cap_pc     <= entry_pc;
      end
   end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
   import dbg_entry_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned WP_SKEW    = 5,
   parameter bit          EXT_EN     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_valid,
   input  logic            ex_bkpt,
   input  logic [PC_W-1:0] ex_pc,
   input  logic            ex_done,
   input  logic            ex_busy,
   input  logic            mem_wp,
   input  logic            ext_req,
   input  logic            resume,
   output logic            dbg_active,
   output logic            ex_squash,
   output logic            irq_mask,
   output logic [1:0]      cause,
   output logic            wp_seen,
   output logic [PC_W-1:0] cap_pc
);
   initial begin
      if (PC_W < 8 || PC_W > 64) $error("dbg_entry_ctrl: PC_W out of range");
      if (INSN_BYTES == 0 || (INSN_BYTES & (INSN_BYTES - 1)) != 0)
         $error("dbg_entry_ctrl: INSN_BYTES must be a power of two");
      if (WP_SKEW == 0 || WP_SKEW > 16) $error("dbg_entry_ctrl: WP_SKEW out of range");
   end

   logic            follow_done, armed, wp_pending, wp_idle;
   entry_t          ent;
   logic [PC_W-1:0] entry_pc;
   cause_e          cause_q;

   assign follow_done = ex_valid && ex_done && !ex_busy;

   dbg_wp_tracker u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_active  (dbg_active),
      .entry       (ent.hit),
      .mem_wp      (mem_wp),
      .follow_done (follow_done),
      .armed       (armed),
      .pending     (wp_pending),
      .idle        (wp_idle)
   );

   dbg_entry_arb #(
      .PC_W       (PC_W),
      .INSN_BYTES (INSN_BYTES),
      .WP_SKEW    (WP_SKEW),
      .EXT_EN     (EXT_EN)
   ) u_arb (
      .dbg_active (dbg_active),
      .ex_valid   (ex_valid),
      .ex_bkpt    (ex_bkpt),
      .ex_pc      (ex_pc),
      .armed      (armed),
      .wp_pending (wp_pending),
      .wp_idle    (wp_idle),
      .mem_wp     (mem_wp),
      .ext_req    (ext_req),
      .ent        (ent),
      .entry_pc   (entry_pc)
   );

   dbg_state_reg #(.PC_W(PC_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .ent        (ent),
      .entry_pc   (entry_pc),
      .resume     (resume),
      .dbg_active (dbg_active),
      .irq_mask   (irq_mask),
      .cause      (cause_q),
      .wp_seen    (wp_seen),
      .cap_pc     (cap_pc)
   );

   assign ex_squash = ent.hit;
   assign cause     = cause_q;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ex_valid,
   input logic            ex_bkpt,
   input logic            resume,
   input logic            dbg_active,
   input logic            ex_squash,
   input logic            irq_mask,
   input logic [1:0]      cause,
   input logic [PC_W-1:0] cap_pc
);
   assert_bkpt_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_active && ex_valid && ex_bkpt) |=> (dbg_active && cause == 2'b01));

   assert_entry_via_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_active && !ex_squash) |=> !dbg_active);

   assert_no_squash_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_active |-> !ex_squash);

   assert_hold_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_active && !resume) |=> (dbg_active && $stable(cap_pc) && $stable(cause)));

   assert_mask_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_active |-> irq_mask);

   assert_mask_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_active && resume) |=> (!dbg_active && !irq_mask));

   assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_active |-> cause == 2'b00);
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ex_valid   (ex_valid),
   .ex_bkpt    (ex_bkpt),
   .resume     (resume),
   .dbg_active (dbg_active),
   .ex_squash  (ex_squash),
   .irq_mask   (irq_mask),
   .cause      (cause),
   .cap_pc     (cap_pc)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
   localparam int PC_W = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ex_valid = 0, ex_bkpt = 0, ex_done = 0, ex_busy = 0;
   logic mem_wp = 0, ext_req = 0, resume = 0;
   logic [PC_W-1:0] ex_pc = '0;
   logic dbg_active, ex_squash, irq_mask, wp_seen;
   logic [1:0] cause;
   logic [PC_W-1:0] cap_pc;

   int checks = 0, errors = 0;

   typedef struct {
      logic [1:0]      cause;
      logic [PC_W-1:0] pc;
      logic            wps;
      string           req;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   dbg_entry_ctrl #(.PC_W(PC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_bkpt(ex_bkpt),
      .ex_pc(ex_pc), .ex_done(ex_done), .ex_busy(ex_busy), .mem_wp(mem_wp),
      .ext_req(ext_req), .resume(resume), .dbg_active(dbg_active),
      .ex_squash(ex_squash), .irq_mask(irq_mask), .cause(cause),
      .wp_seen(wp_seen), .cap_pc(cap_pc)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver side of the scoreboard: one expected halt record
   task automatic push_exp(logic [1:0] c, logic [PC_W-1:0] pc, logic w, string req);
      exp_t e;
      e.cause = c; e.pc = pc; e.wps = w; e.req = req;
      sb_q.push_back(e);
   endtask

   // drive one cycle at the falling edge, check the cancel line, advance
   task automatic step(logic v, logic b, logic [PC_W-1:0] pc, logic d, logic bz,
                       logic w, logic x, logic r, logic exp_sq, string req);
      ex_valid = v; ex_bkpt = b; ex_pc = pc; ex_done = d; ex_busy = bz;
      mem_wp = w; ext_req = x; resume = r;
      #1;
      chk(req, "ex_squash", 64'(ex_squash), 64'(exp_sq));
      @(negedge clk);
   endtask

   task automatic idle_cyc();
      step(0, 0, '0, 0, 0, 0, 0, 0, 0, "R9");
   endtask

   task automatic leave_debug(string req);
      step(0, 0, '0, 0, 0, 0, 0, 1, 0, req);
      chk(req, "dbg_active after resume", 64'(dbg_active), 64'd0);
      chk("R3", "irq_mask after resume", 64'(irq_mask), 64'd0);
      chk("R10", "cause after resume", 64'(cause), 64'd0);
   endtask

   // monitor side: compare each new halt against the queue head
   logic prev_dbg = 1'b0;
   always @(negedge clk) begin
      if (rst_n && dbg_active && !prev_dbg) begin
         if (sb_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected halt: actual=cause %0b expected=no halt", cause);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "cause", 64'(cause), 64'(e.cause));
            chk(e.req, "cap_pc", 64'(cap_pc), 64'(e.pc));
            chk("R7", "wp_seen", 64'(wp_seen), 64'(e.wps));
            chk("R3", "irq_mask at entry", 64'(irq_mask), 64'd1);
         end
      end
      prev_dbg <= rst_n && dbg_active;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "dbg_active in reset", 64'(dbg_active), 64'd0);
      chk("R11", "irq_mask in reset", 64'(irq_mask), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "cause after reset", 64'(cause), 64'd0);
      chk("R11", "wp_seen after reset", 64'(wp_seen), 64'd0);
      step(1, 0, 32'h0F0, 1, 0, 0, 0, 0, 0, "R11");
      step(1, 0, 32'h0F4, 1, 0, 0, 0, 1, 0, "R9");   // resume outside debug
      chk("R9", "stray resume", 64'(dbg_active), 64'd0);
      step(0, 1, 32'h0F8, 0, 0, 0, 0, 0, 0, "R1");   // tag without valid
      chk("R1", "tag without valid", 64'(dbg_active), 64'd0);

      // breakpoint halt
      push_exp(2'b01, 32'h100, 1'b0, "R1");
      step(1, 1, 32'h100, 0, 0, 0, 0, 0, 1, "R1");
      chk("R1", "dbg_active", 64'(dbg_active), 64'd1);
      step(1, 1, 32'h104, 1, 0, 1, 1, 0, 0, "R9");   // ignored while halted
      idle_cyc();
      chk("R9", "cause held", 64'(cause), 64'd1);
      chk("R9", "cap_pc held", 64'(cap_pc), 64'h100);
      leave_debug("R9");

      // refetched breakpoint fires again
      push_exp(2'b01, 32'h100, 1'b0, "R2");
      step(1, 1, 32'h100, 0, 0, 0, 0, 0, 1, "R2");
      chk("R2", "re-entry", 64'(dbg_active), 64'd1);
      leave_debug("R2");

      // watchpoint, single-cycle follow-on
      push_exp(2'b10, 32'h218, 1'b0, "R6");
      step(1, 0, 32'h200, 1, 0, 1, 0, 0, 0, "R4");
      step(1, 0, 32'h204, 1, 0, 0, 0, 0, 1, "R4");
      chk("R4", "dbg after wp", 64'(dbg_active), 64'd1);
      leave_debug("R4");

      // watchpoint, multi-cycle follow-on
      push_exp(2'b10, 32'h318, 1'b0, "R5");
      step(1, 0, 32'h300, 0, 1, 1, 0, 0, 0, "R5");
      step(1, 0, 32'h300, 0, 1, 0, 0, 0, 0, "R5");
      step(1, 0, 32'h300, 1, 0, 0, 0, 0, 0, "R5");
      step(1, 0, 32'h304, 1, 0, 0, 0, 0, 1, "R5");
      leave_debug("R5");

      // follow-on is a taken branch
      push_exp(2'b10, 32'h814, 1'b0, "R6");
      step(1, 0, 32'h400, 1, 0, 1, 0, 0, 0, "R6");
      step(1, 0, 32'h800, 1, 0, 0, 0, 0, 1, "R6");
      leave_debug("R6");

      // bubble after the follow-on
      push_exp(2'b10, 32'h714, 1'b0, "R5");
      step(1, 0, 32'h6F0, 1, 0, 1, 0, 0, 0, "R5");
      step(0, 0, 32'h6F4, 0, 0, 0, 0, 0, 0, "R5");
      step(1, 0, 32'h700, 1, 0, 0, 0, 0, 1, "R5");
      leave_debug("R5");

      // breakpoint beats a pending watchpoint
      push_exp(2'b01, 32'h504, 1'b1, "R7");
      step(1, 0, 32'h500, 1, 0, 1, 0, 0, 0, "R7");
      step(1, 1, 32'h504, 0, 0, 0, 0, 0, 1, "R7");
      leave_debug("R7");

      // external request
      push_exp(2'b11, 32'h600, 1'b0, "R8");
      step(1, 0, 32'h600, 0, 0, 0, 1, 0, 1, "R8");
      chk("R8", "dbg after ext", 64'(dbg_active), 64'd1);
      leave_debug("R8");

      idle_cyc();
      chk("R9", "scoreboard drained", 64'(sb_q.size()), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule